// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block writes one byte into a UV-erasable EPROM and then reads it back to confirm the write. A host presents an address and a byte and strobes a start input. The sequencer then does the following:

- It asks an external supply switch to raise the programming voltage.
- It drives the address and the data byte onto the memory.
- It lowers the active-low chip-enable/program line for one long program pulse.
- It releases the data bus and lowers the active-low output enable, so it can compare what the part returns with the byte it wrote.

If the byte read back differs, the sequencer applies another pulse, up to a configurable limit. It finishes with a one-cycle done strobe and a fail flag.

Every interval is a parameter counted in clock cycles. These intervals are the setup before the pulse, the pulse width, the data hold after the pulse, the read access time and the bus float time. One instance can therefore meet the microsecond-scale programming rules at any clock rate.

The program line only ever moves while the programming voltage is steady and already requested. The sequencer's drive on the bus always ends before the memory's outputs are enabled.

Top module: `eprom_prog_seq`

## Requirements
- R1: While reset is high and after it: prog_ce_n_o=1, prog_oe_n_o=1, vpp_req_o=0, dq_drive_o=0, busy_o=0, done_o=0, fail_o=0.
- R2: A start_i sampled high while idle latches addr_i and data_i onto mem_addr_o and mem_dq_o. In the next cycle it sets busy_o, vpp_req_o and dq_drive_o. It then keeps prog_ce_n_o and prog_oe_n_o high for SETUP_CYC cycles before the pulse.
- R3: prog_ce_n_o stays low for exactly PULSE_CYC consecutive cycles per pulse. During the pulse prog_oe_n_o stays high and vpp_req_o stays high.
- R4: After prog_ce_n_o rises, dq_drive_o stays high for HOLD_CYC cycles. Then comes one cycle with dq_drive_o low and prog_oe_n_o still high. prog_oe_n_o never falls in a cycle that follows one with dq_drive_o high.
- R5: prog_oe_n_o is low for READ_CYC cycles. mem_dq_i is compared with the latched byte at the end of the last of these cycles. dq_drive_o is never high while prog_oe_n_o is low.
- R6: vpp_req_o never changes in a cycle where prog_ce_n_o is low, and prog_ce_n_o is low only while vpp_req_o is high.
- R7: On a mismatch, the sequence repeats from the setup phase, with the programming voltage kept up. At most MAX_PULSES pulses are applied per start.
- R8: After a match or the last allowed pulse, done_o is high for exactly one cycle, with vpp_req_o low and busy_o high. fail_o is 1 on a final mismatch and 0 on a match. It holds that value until the next accepted start, which clears it.
- R9: start_i is ignored while busy_o is high. The outputs, the latched address and byte, and the pulse count are unaffected.
- R10: After each verify read, prog_oe_n_o stays high with dq_drive_o low for FLOAT_CYC cycles. Only then does the next setup phase or the done cycle follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| addr_i | input | ADDR_W | Target address |
| data_i | input | 8 | Byte to program |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence strobe |
| fail_o | output | 1 | Verify failed after the last pulse |
| mem_addr_o | output | ADDR_W | Address to the memory |
| mem_dq_o | output | 8 | Byte driven to the memory data bus |
| dq_drive_o | output | 1 | Enable for the data bus drivers |
| mem_dq_i | input | 8 | Data read back from the memory |
| prog_ce_n_o | output | 1 | Active-low chip enable / program pulse |
| prog_oe_n_o | output | 1 | Active-low output enable |
| vpp_req_o | output | 1 | Request for the programming voltage |

## Verification
The bench builds the sequencer with very short intervals: SETUP_CYC=3, PULSE_CYC=8, HOLD_CYC=2, READ_CYC=2 and FLOAT_CYC=2, with MAX_PULSES=3. One full attempt then takes about eighteen cycles, so every phase boundary can be compared cycle by cycle. With MAX_PULSES=3, a device model that needs one, three or four pulses reaches the first-try pass, the pass on the last allowed pulse and the exhausted fail within a few hundred cycles. The short windows also let a second start land inside the pulse phase, which checks that it is ignored.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_TURN,
        ST_READ,
        ST_RECOVER,
        ST_DONE
    } prog_state_e;

    // Control pin levels for one phase.
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic vpp;
        logic drive;
    } pin_ctl_t;

    function automatic pin_ctl_t ctl_for(prog_state_e s);
        pin_ctl_t c;
        c = '{ce_n: 1'b1, oe_n: 1'b1, vpp: 1'b0, drive: 1'b0};
        case (s)
            ST_SETUP, ST_HOLD: begin c.vpp = 1'b1; c.drive = 1'b1; end
            ST_PULSE:          begin c.vpp = 1'b1; c.drive = 1'b1; c.ce_n = 1'b0; end
            ST_TURN, ST_RECOVER: c.vpp = 1'b1;
            ST_READ:           begin c.vpp = 1'b1; c.oe_n = 1'b0; end
            default: ;
        endcase
        return c;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign last = (cnt == limit - 1'b1);
endmodule

// File: rtl/prog_attempts.sv
module prog_attempts #(
    parameter int W   = 4,
    parameter int MAX = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic exhausted
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (bump)    cnt <= cnt + 1'b1;
    end

    assign exhausted = (cnt >= W'(MAX));
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int SETUP_CYC  = 250,
    parameter int PULSE_CYC  = 93750,
    parameter int HOLD_CYC   = 250,
    parameter int READ_CYC   = 8,
    parameter int FLOAT_CYC  = 8,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_dq_o,
    output logic              dq_drive_o,
    input  logic [7:0]        mem_dq_i,
    output logic              prog_ce_n_o,
    output logic              prog_oe_n_o,
    output logic              vpp_req_o
);
    localparam int unsigned LONGEST = max_u(max_u(max_u(SETUP_CYC, PULSE_CYC),
                                                  max_u(HOLD_CYC, READ_CYC)),
                                            max_u(FLOAT_CYC, 2));
    localparam int TMR_W = $clog2(LONGEST + 1);
    localparam int ATT_W = $clog2(MAX_PULSES + 1);

    prog_state_e       state, state_nx;
    logic [TMR_W-1:0]  limit;
    logic              last, exhausted, match_q, fail_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    pin_ctl_t          ctl;
    logic              accept;

    assign accept = (state == ST_IDLE) && start_i;

    always_comb begin
        case (state)
            ST_SETUP:   limit = TMR_W'(SETUP_CYC);
            ST_PULSE:   limit = TMR_W'(PULSE_CYC);
            ST_HOLD:    limit = TMR_W'(HOLD_CYC);
            ST_READ:    limit = TMR_W'(READ_CYC);
            ST_RECOVER: limit = TMR_W'(FLOAT_CYC);
            default:    limit = TMR_W'(1);
        endcase
    end

    prog_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart ((state_nx != state) || (state == ST_IDLE)),
        .limit   (limit),
        .last    (last)
    );

    prog_attempts #(.W(ATT_W), .MAX(MAX_PULSES)) u_attempts (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .bump      ((state == ST_PULSE) && last),
        .exhausted (exhausted)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:    if (start_i) state_nx = ST_SETUP;
            ST_SETUP:   if (last) state_nx = ST_PULSE;
            ST_PULSE:   if (last) state_nx = ST_HOLD;
            ST_HOLD:    if (last) state_nx = ST_TURN;
            ST_TURN:    state_nx = ST_READ;
            ST_READ:    if (last) state_nx = ST_RECOVER;
            ST_RECOVER: if (last) state_nx = (match_q || exhausted) ? ST_DONE : ST_SETUP;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            match_q <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                addr_q <= addr_i;
                data_q <= data_i;
                fail_q <= 1'b0;
            end
            if ((state == ST_READ) && last)
                match_q <= (mem_dq_i == data_q);
            if ((state == ST_RECOVER) && (state_nx == ST_DONE))
                fail_q <= !match_q;
        end
    end

    assign ctl         = ctl_for(state);
    assign prog_ce_n_o = ctl.ce_n;
    assign prog_oe_n_o = ctl.oe_n;
    assign vpp_req_o   = ctl.vpp;
    assign dq_drive_o  = ctl.drive;
    assign busy_o      = (state != ST_IDLE);
    assign done_o      = (state == ST_DONE);
    assign fail_o      = fail_q;
    assign mem_addr_o  = addr_q;
    assign mem_dq_o    = data_q;
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
    parameter int ADDR_W    = 15,
    parameter int PULSE_CYC = 93750
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [7:0]        mem_dq_o,
    input logic              dq_drive_o,
    input logic              prog_ce_n_o,
    input logic              prog_oe_n_o,
    input logic              vpp_req_o
);
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || prog_ce_n_o) low_run <= '0;
        else                    low_run <= low_run + 1;
    end

    p_pulse_bound_r3: assert property (@(posedge clk) disable iff (rst)
        !prog_ce_n_o |-> (low_run < 32'(PULSE_CYC)));

    p_pulse_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_ce_n_o) |-> (low_run == 32'(PULSE_CYC)));

    p_pulse_oe_high_r3: assert property (@(posedge clk) disable iff (rst)
        !prog_ce_n_o |-> prog_oe_n_o);

    p_vpp_steady_r6: assert property (@(posedge clk) disable iff (rst)
        !prog_ce_n_o |-> (vpp_req_o && $stable(vpp_req_o)));

    p_pulse_entry_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_ce_n_o) |-> (dq_drive_o && vpp_req_o));

    p_no_clash_r5: assert property (@(posedge clk) disable iff (rst)
        !prog_oe_n_o |-> !dq_drive_o);

    p_turnaround_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_oe_n_o) |-> !$past(dq_drive_o));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_vpp_low_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!vpp_req_o && busy_o));

    p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .dq_drive_o  (dq_drive_o),
    .prog_ce_n_o (prog_ce_n_o),
    .prog_oe_n_o (prog_oe_n_o),
    .vpp_req_o   (vpp_req_o)
);

// File: tb/eprom_prog_seq_test.sv
`timescale 1ns/1ps
module eprom_prog_seq_test;
    localparam int AW = 15;
    localparam int S  = 3;
    localparam int P  = 8;
    localparam int H  = 2;
    localparam int R  = 2;
    localparam int F  = 2;
    localparam int MX = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    data_i = '0;
    logic          busy_o, done_o, fail_o, dq_drive_o, prog_ce_n_o, prog_oe_n_o, vpp_req_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_dq_o, mem_dq_i;

    int checks = 0;
    int errors = 0;

    // Expected per-cycle tuple: {busy, ce_n, oe_n, vpp, drive, done, fail}
    logic [6:0]    expq[$];
    logic          idle_fail = 1'b0;
    logic          mon_on = 1'b0;
    logic [AW-1:0] exp_addr = '0;
    logic [7:0]    exp_data = '0;
    int            pulses = 0;
    int            need = 1;
    logic          prev_ce = 1'b1;

    always #4 clk = ~clk;

    // Memory model: returns the written byte once enough pulses were applied.
    assign mem_dq_i = (!prog_oe_n_o && pulses >= need) ? exp_data : 8'hFF;

    eprom_prog_seq #(
        .ADDR_W(AW), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
        .READ_CYC(R), .FLOAT_CYC(F), .MAX_PULSES(MX)
    ) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .dq_drive_o(dq_drive_o),
        .mem_dq_i(mem_dq_i), .prog_ce_n_o(prog_ce_n_o), .prog_oe_n_o(prog_oe_n_o),
        .vpp_req_o(vpp_req_o)
    );

    task automatic cmp(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic push_n(int n, logic [6:0] v);
        for (int i = 0; i < n; i++) expq.push_back(v);
    endtask

    always @(negedge clk) begin
        if (prev_ce == 1'b0 && prog_ce_n_o == 1'b1) pulses++;
        prev_ce = prog_ce_n_o;
        if (mon_on) begin
            logic [6:0] e;
            e = (expq.size() > 0) ? expq.pop_front() : {6'b011000, idle_fail};
            cmp("R2", "busy_o",      busy_o,      e[6]);
            cmp("R3", "prog_ce_n_o", prog_ce_n_o, e[5]);
            cmp("R5", "prog_oe_n_o", prog_oe_n_o, e[4]);
            cmp("R6", "vpp_req_o",   vpp_req_o,   e[3]);
            cmp("R4", "dq_drive_o",  dq_drive_o,  e[2]);
            cmp("R8", "done_o",      done_o,      e[1]);
            cmp("R8", "fail_o",      fail_o,      e[0]);
            if (e[1]) idle_fail = e[0];
            if (e[6]) begin
                cmp("R9", "mem_addr_o", int'(mem_addr_o), int'(exp_addr));
                cmp("R9", "mem_dq_o",   int'(mem_dq_o),   int'(exp_data));
            end
        end
    end

    task automatic run_one(logic [AW-1:0] a, logic [7:0] d, int nd, logic poke);
        int att;
        logic fl;
        @(negedge clk); #1;
        exp_addr = a; exp_data = d; need = nd; pulses = 0;
        addr_i = a; data_i = d; start_i = 1'b1;
        att = 0;
        forever begin
            att++;
            push_n(S, 7'b1111100);   // R2 setup
            push_n(P, 7'b1011100);   // R3 pulse
            push_n(H, 7'b1111100);   // R4 data hold
            push_n(1, 7'b1111000);   // R4 turnaround
            push_n(R, 7'b1101000);   // R5 read
            push_n(F, 7'b1111000);   // R10 float
            if (att >= nd || att == MX) break;   // R7 retry limit
        end
        fl = (att < nd);
        push_n(1, {6'b111001, fl});
        @(negedge clk); #1;
        start_i = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            #1; start_i = 1'b1; addr_i = ~a; data_i = ~d;    // R9 start while busy
            @(negedge clk); #1; start_i = 1'b0;
        end
        while (expq.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        cmp("R7", "pulse count", pulses, att);
        cmp("R8", "fail_o held", fail_o, fl);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1", "ce_n in reset",  prog_ce_n_o, 1);
        cmp("R1", "oe_n in reset",  prog_oe_n_o, 1);
        cmp("R1", "vpp in reset",   vpp_req_o,   0);
        cmp("R1", "drive in reset", dq_drive_o,  0);
        cmp("R1", "busy in reset",  busy_o,      0);
        cmp("R1", "done in reset",  done_o,      0);
        cmp("R1", "fail in reset",  fail_o,      0);
        #1 rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;
        run_one(15'h1234, 8'h5A, 1, 1'b0);   // pass on first pulse
        run_one(15'h7FFF, 8'hC3, 3, 1'b0);   // pass on last allowed pulse
        run_one(15'h0001, 8'h00, 4, 1'b0);   // exhausted: fail
        run_one(15'h2AAA, 8'h96, 2, 1'b1);   // clears fail; ignored start
        run_one(15'h0000, 8'h3C, 1, 1'b1);
        mon_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule